// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block decides whether a control transfer in an integer pipeline is taken, and where it goes. Each cycle with `in_valid` high it takes the instruction address, two register operands, a sign-extended immediate, a transfer kind and a comparison selector. Exactly one clock edge later it presents the result: a taken flag, the computed target, the next fetch address, the sequential return value (instruction address plus four), a write enable for the link register, and an exception flag for a misaligned target.

The immediate arrives already assembled and sign-extended. Fetch, decode and trap handling are outside the block. The datapath width is a parameter that selects 32 or 64 bits, and all address sums wrap at that width. Every instruction occupies four bytes on a four-byte boundary, and transfers have no delay slot. A taken transfer therefore redirects fetch straight to its target. A taken transfer whose target breaks alignment raises the exception against the transferring instruction's own address. A branch that falls through never raises it.

Top module: `br_resolve_unit`

## Requirements
- R1: With `in_kind`=1 (conditional), `in_cmp` selects the condition on `in_op_a` against `in_op_b`. The codes are 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal. A true condition makes the branch taken.
- R2: Comparison codes 2 and 3 are unsupported. A conditional transfer that uses them is never taken.
- R3: Kind 2 (direct jump) and kind 3 (register jump) are always taken. Kind 0 (no transfer) is never taken.
- R4: For kinds 0, 1 and 2 the target is `in_pc` + `in_imm`. For kind 3 it is `in_op_a` + `in_imm` with bit 0 then forced to zero.
- R5: A taken transfer whose target has either of its two low bits set raises `out_misalign`.
- R6: A transfer that is not taken never raises `out_misalign`, even when its target is misaligned.
- R7: When `out_misalign` is high, `out_fault_pc` equals the address of the transferring instruction. Otherwise `out_fault_pc` is zero.
- R8: `out_link` is `in_pc` + 4 on every valid result. `out_link_we` is high for kinds 2 and 3 unless that jump raises `out_misalign`.
- R9: `out_next_pc` is the target when the transfer is taken, and `in_pc` + 4 otherwise.
- R10: All address sums wrap modulo 2 to the power of the datapath width.
- R11: Results appear exactly one cycle after the request. While reset is held, and in any cycle with `out_valid` low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_pc | input | XLEN | Address of the transferring instruction |
| in_op_a | input | XLEN | First register operand (comparison left side, register-jump base) |
| in_op_b | input | XLEN | Second register operand (comparison right side) |
| in_imm | input | XLEN | Sign-extended offset |
| in_kind | input | 2 | 0 none, 1 conditional, 2 direct jump, 3 register jump |
| in_cmp | input | 3 | Comparison selector for conditional transfers |
| out_valid | output | 1 | Result present this cycle |
| out_taken | output | 1 | Transfer redirects fetch |
| out_target | output | XLEN | Computed target address |
| out_next_pc | output | XLEN | Address to fetch next |
| out_link | output | XLEN | Sequential return address |
| out_link_we | output | 1 | Write `out_link` into the destination register |
| out_misalign | output | 1 | Misaligned-target exception |
| out_fault_pc | output | XLEN | Address reported with the exception |

## Verification
On every cycle the assertions enforce the relations between outputs. The exception implies a taken transfer with a low target bit set, and no link write accompanies it. The reported fault address and the return value track the request address from one cycle earlier. Jumps are always taken and register-jump targets are even. The next-fetch address follows the taken flag, and idle cycles are quiet. The correctness of each comparison, including signed against unsigned ordering of the same bit patterns, can only be shown by the bench's scenarios. The same holds for sum wraparound at the top of the address space and for back-to-back requests being paired with the right results.

// File: rtl/br_pkg.sv
package br_pkg;

   // Transfer kind carried with each request
   typedef enum logic [1:0] {
      XFER_NONE     = 2'd0,
      XFER_COND     = 2'd1,
      XFER_DIRECT   = 2'd2,
      XFER_INDIRECT = 2'd3
   } xfer_kind_e;

   // Comparison selector; codes 2 and 3 are unused and never satisfy
   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_NE  = 3'd1,
      CMP_LT  = 3'd4,
      CMP_GE  = 3'd5,
      CMP_LTU = 3'd6,
      CMP_GEU = 3'd7
   } cmp_sel_e;

   localparam int unsigned KIND_W = 2;
   localparam int unsigned CMP_W  = 3;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
   import br_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CMP_STYLE = 0
) (
   input  logic [XLEN-1:0]  op_a,
   input  logic [XLEN-1:0]  op_b,
   input  logic [CMP_W-1:0] sel,
   output logic             cond_true
);

   localparam int unsigned MSB = XLEN - 1;

   logic is_eq;
   logic is_lt;
   logic is_ltu;

   generate
      if (CMP_STYLE > 1) begin : g_bad_style
         $error("br_cond_eval: CMP_STYLE must be 0 or 1");
      end

      if (CMP_STYLE == 0) begin : g_native
         // Independent relational operators
         assign is_eq  = (op_a == op_b);
         assign is_lt  = ($signed(op_a) < $signed(op_b));
         assign is_ltu = (op_a < op_b);
      end else begin : g_subtract
         // One shared subtractor; borrow gives unsigned order,
         // sign agreement decides the signed result
         logic [XLEN:0] diff;
         logic          sign_differs;
         assign diff         = {1'b0, op_a} - {1'b0, op_b};
         assign sign_differs = op_a[MSB] ^ op_b[MSB];
         assign is_eq        = (diff[MSB:0] == '0);
         assign is_ltu       = diff[XLEN];
         assign is_lt        = sign_differs ? op_a[MSB] : diff[MSB];
      end
   endgenerate

   always_comb begin
      case (cmp_sel_e'(sel))
         CMP_EQ:  cond_true = is_eq;
         CMP_NE:  cond_true = !is_eq;
         CMP_LT:  cond_true = is_lt;
         CMP_GE:  cond_true = !is_lt;
         CMP_LTU: cond_true = is_ltu;
         CMP_GEU: cond_true = !is_ltu;
         default: cond_true = 1'b0;
      endcase
   end

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned INSTR_BYTES = 4
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] imm,
   input  logic            indirect,
   output logic [XLEN-1:0] target,
   output logic [XLEN-1:0] seq_pc
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   logic [XLEN-1:0] rel_sum;
   logic [XLEN-1:0] ind_sum;
   logic [XLEN-1:0] ind_even;

   // Sums are XLEN wide, so carries out of the top bit are dropped
   assign rel_sum  = pc + imm;
   assign ind_sum  = base + imm;
   assign ind_even = {ind_sum[XLEN-1:1], 1'b0};
   assign target   = indirect ? ind_even : rel_sum;
   assign seq_pc   = pc + STEP;

endmodule

// File: rtl/br_align_check.sv
module br_align_check #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned ALIGN_LOG2 = 2
) (
   input  logic [XLEN-1:0] addr,
   output logic            misaligned
);

   generate
      if (ALIGN_LOG2 == 0) begin : g_any
         assign misaligned = 1'b0;
      end else begin : g_low
         assign misaligned = |addr[ALIGN_LOG2-1:0];
      end
   endgenerate

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
   import br_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned CMP_STYLE  = 0,
   parameter int unsigned ALIGN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [XLEN-1:0]   in_pc,
   input  logic [XLEN-1:0]   in_op_a,
   input  logic [XLEN-1:0]   in_op_b,
   input  logic [XLEN-1:0]   in_imm,
   input  logic [KIND_W-1:0] in_kind,
   input  logic [CMP_W-1:0]  in_cmp,
   output logic              out_valid,
   output logic              out_taken,
   output logic [XLEN-1:0]   out_target,
   output logic [XLEN-1:0]   out_next_pc,
   output logic [XLEN-1:0]   out_link,
   output logic              out_link_we,
   output logic              out_misalign,
   output logic [XLEN-1:0]   out_fault_pc
);

   localparam int unsigned INSTR_BYTES = 1 << ALIGN_LOG2;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("br_resolve_unit: XLEN must be 32 or 64");
      end
      if (ALIGN_LOG2 >= 8) begin : g_bad_align
         $error("br_resolve_unit: ALIGN_LOG2 out of range");
      end
   endgenerate

   logic            is_cond;
   logic            is_jump;
   logic            is_indirect;
   logic            cond_true;
   logic [XLEN-1:0] tgt;
   logic [XLEN-1:0] seq;
   logic            tgt_bad;
   logic            taken_c;
   logic            fault_c;

   assign is_cond     = (xfer_kind_e'(in_kind) == XFER_COND);
   assign is_indirect = (xfer_kind_e'(in_kind) == XFER_INDIRECT);
   assign is_jump     = is_indirect || (xfer_kind_e'(in_kind) == XFER_DIRECT);

   br_cond_eval #(
      .XLEN      (XLEN),
      .CMP_STYLE (CMP_STYLE)
   ) u_cond (
      .op_a      (in_op_a),
      .op_b      (in_op_b),
      .sel       (in_cmp),
      .cond_true (cond_true)
   );

   br_target_gen #(
      .XLEN        (XLEN),
      .INSTR_BYTES (INSTR_BYTES)
   ) u_tgt (
      .pc       (in_pc),
      .base     (in_op_a),
      .imm      (in_imm),
      .indirect (is_indirect),
      .target   (tgt),
      .seq_pc   (seq)
   );

   br_align_check #(
      .XLEN       (XLEN),
      .ALIGN_LOG2 (ALIGN_LOG2)
   ) u_align (
      .addr       (tgt),
      .misaligned (tgt_bad)
   );

   assign taken_c = is_jump || (is_cond && cond_true);
   assign fault_c = taken_c && tgt_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_taken    <= 1'b0;
         out_target   <= '0;
         out_next_pc  <= '0;
         out_link     <= '0;
         out_link_we  <= 1'b0;
         out_misalign <= 1'b0;
         out_fault_pc <= '0;
      end else if (in_valid) begin
         out_valid    <= 1'b1;
         out_taken    <= taken_c;
         out_target   <= tgt;
         out_next_pc  <= taken_c ? tgt : seq;
         out_link     <= seq;
         out_link_we  <= is_jump && !fault_c;
         out_misalign <= fault_c;
         out_fault_pc <= fault_c ? in_pc : '0;
      end else begin
         out_valid    <= 1'b0;
         out_taken    <= 1'b0;
         out_target   <= '0;
         out_next_pc  <= '0;
         out_link     <= '0;
         out_link_we  <= 1'b0;
         out_misalign <= 1'b0;
         out_fault_pc <= '0;
      end
   end

endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned ALIGN_LOG2 = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] in_pc,
   input logic [1:0]      in_kind,
   input logic            out_valid,
   input logic            out_taken,
   input logic [XLEN-1:0] out_target,
   input logic [XLEN-1:0] out_next_pc,
   input logic [XLEN-1:0] out_link,
   input logic            out_link_we,
   input logic            out_misalign,
   input logic [XLEN-1:0] out_fault_pc
);

   localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_LOG2);

   AST_FAULT_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_misalign |-> out_taken);                                        // R6
   AST_FAULT_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      out_misalign |-> (out_target[1:0] != 2'b00));                       // R5
   AST_TAKEN_BAD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_taken && out_target[1:0] != 2'b00) |-> out_misalign);          // R5
   AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_misalign |-> (out_fault_pc == $past(in_pc)));                   // R7
   AST_FAULT_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !out_misalign |-> (out_fault_pc == '0));                            // R7
   AST_NO_LINK_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      out_misalign |-> !out_link_we);                                     // R8
   AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_link == $past(in_pc) + STEP));                   // R8
   AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_kind) >= 2'd2) |-> out_taken);               // R3
   AST_NONE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_kind) == 2'd0) |-> !out_taken);              // R3
   AST_INDIRECT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_kind) == 2'd3) |-> !out_target[0]);          // R4
   AST_NEXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_next_pc == (out_taken ? out_target : out_link))); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_taken && !out_misalign && !out_link_we));      // R11

endmodule

bind br_resolve_unit br_resolve_chk #(
   .XLEN       (XLEN),
   .ALIGN_LOG2 (ALIGN_LOG2)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_pc        (in_pc),
   .in_kind      (in_kind),
   .out_valid    (out_valid),
   .out_taken    (out_taken),
   .out_target   (out_target),
   .out_next_pc  (out_next_pc),
   .out_link     (out_link),
   .out_link_we  (out_link_we),
   .out_misalign (out_misalign),
   .out_fault_pc (out_fault_pc)
);

// File: tb/sim_br_resolve_unit.sv
`timescale 1ns/1ps
module sim_br_resolve_unit;

   typedef struct {
      logic        taken;
      logic [31:0] target;
      logic [31:0] next_pc;
      logic [31:0] link;
      logic        link_we;
      logic        mis;
      logic [31:0] fault;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_pc = '0;
   logic [31:0] in_op_a = '0;
   logic [31:0] in_op_b = '0;
   logic [31:0] in_imm = '0;
   logic [1:0]  in_kind = '0;
   logic [2:0]  in_cmp = '0;
   logic        out_valid;
   logic        out_taken;
   logic [31:0] out_target;
   logic [31:0] out_next_pc;
   logic [31:0] out_link;
   logic        out_link_we;
   logic        out_misalign;
   logic [31:0] out_fault_pc;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   br_resolve_unit #(.XLEN(32), .CMP_STYLE(0), .ALIGN_LOG2(2)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
      .in_op_a(in_op_a), .in_op_b(in_op_b), .in_imm(in_imm),
      .in_kind(in_kind), .in_cmp(in_cmp), .out_valid(out_valid),
      .out_taken(out_taken), .out_target(out_target),
      .out_next_pc(out_next_pc), .out_link(out_link),
      .out_link_we(out_link_we), .out_misalign(out_misalign),
      .out_fault_pc(out_fault_pc)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] pc, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] imm,
                                  input logic [1:0] kind, input logic [2:0] cmp,
                                  input string tag);
      exp_t e;
      logic c;
      case (cmp)
         3'd0: c = (a == b);
         3'd1: c = (a != b);
         3'd4: c = ($signed(a) <  $signed(b));
         3'd5: c = ($signed(a) >= $signed(b));
         3'd6: c = (a <  b);
         3'd7: c = (a >= b);
         default: c = 1'b0;
      endcase
      e.target  = (kind == 2'd3) ? ((a + imm) & 32'hFFFF_FFFE) : (pc + imm);
      e.taken   = (kind >= 2'd2) || (kind == 2'd1 && c);
      e.mis     = e.taken && (e.target[1:0] != 2'b00);
      e.link    = pc + 32'd4;
      e.next_pc = e.taken ? e.target : e.link;
      e.link_we = (kind >= 2'd2) && !e.mis;
      e.fault   = e.mis ? pc : 32'd0;
      e.tag     = tag;
      return e;
   endfunction

   task automatic issue(input logic [31:0] pc, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] imm,
                        input logic [1:0] kind, input logic [2:0] cmp,
                        input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_pc    = pc;
      in_op_a  = a;
      in_op_b  = b;
      in_imm   = imm;
      in_kind  = kind;
      in_cmp   = cmp;
      sb.push_back(model(pc, a, b, imm, kind, cmp, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_kind  = 2'd0;
      end
   endtask

   // Monitor: each result is compared against the oldest expectation
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R11", "unexpected result", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(out_taken == e.taken, e.tag, "taken", 32'(out_taken), 32'(e.taken));
               check(out_target == e.target, e.tag, "target", out_target, e.target);
               check(out_next_pc == e.next_pc, e.tag, "next_pc", out_next_pc, e.next_pc);
               check(out_link == e.link, e.tag, "link", out_link, e.link);
               check(out_link_we == e.link_we, e.tag, "link_we", 32'(out_link_we), 32'(e.link_we));
               check(out_misalign == e.mis, e.tag, "misalign", 32'(out_misalign), 32'(e.mis));
               check(out_fault_pc == e.fault, e.tag, "fault_pc", out_fault_pc, e.fault);
            end
         end
      end
   end

   initial begin
      // R11: outputs are zero while reset is held
      repeat (3) @(negedge clk);
      check(!out_valid && !out_taken && !out_misalign && !out_link_we &&
            out_target == 0 && out_next_pc == 0 && out_link == 0 && out_fault_pc == 0,
            "R11", "reset state", {out_valid, out_taken, out_misalign, out_link_we}, 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R1: each supported comparison, signed versus unsigned orderings
      issue(32'h100, 32'd5, 32'd5, 32'h20, 2'd1, 3'd0, "R1 eq");
      issue(32'h100, 32'd5, 32'd5, 32'h20, 2'd1, 3'd1, "R1 ne");
      issue(32'h100, 32'hFFFF_FFFF, 32'd1, 32'h40, 2'd1, 3'd4, "R1 lt");
      issue(32'h100, 32'hFFFF_FFFF, 32'd1, 32'h40, 2'd1, 3'd6, "R1 ltu");
      issue(32'h100, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 2'd1, 3'd5, "R1 ge");
      issue(32'h100, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 2'd1, 3'd7, "R1 geu");
      issue(32'h200, 32'd9, 32'd9, 32'h8, 2'd1, 3'd5, "R1 ge equal");
      issue(32'h200, 32'd9, 32'd9, 32'h8, 2'd1, 3'd4, "R1 lt equal");
      issue(32'h200, 32'd3, 32'd9, 32'h8, 2'd1, 3'd1, "R1 ne differ");
      // R2: unsupported codes never take, even when operands match
      issue(32'h300, 32'd7, 32'd7, 32'h10, 2'd1, 3'd2, "R2 code2");
      issue(32'h300, 32'd7, 32'd7, 32'h10, 2'd1, 3'd3, "R2 code3");
      idle(1);
      // R3 / R4: direct and register jumps, no-transfer kind
      issue(32'h400, 32'd0, 32'd0, 32'hFFFF_FFF8, 2'd2, 3'd1, "R3 direct back");
      issue(32'h400, 32'h1001, 32'd0, 32'h10, 2'd3, 3'd0, "R4 indirect clr");
      issue(32'h400, 32'h1001, 32'd0, 32'h0, 2'd3, 3'd0, "R4 indirect odd base");
      issue(32'h400, 32'd4, 32'd4, 32'h20, 2'd0, 3'd0, "R3 none");
      // R5 / R7 / R8: taken transfers to misaligned targets
      issue(32'h500, 32'd1, 32'd1, 32'h22, 2'd1, 3'd0, "R5 branch bad");
      issue(32'h504, 32'd0, 32'd0, 32'h6, 2'd2, 3'd0, "R8 direct bad");
      issue(32'h508, 32'h1003, 32'd0, 32'h0, 2'd3, 3'd0, "R7 indirect bad");
      // R6: not-taken branch with misaligned target
      issue(32'h600, 32'd1, 32'd2, 32'h22, 2'd1, 3'd0, "R6 fallthrough");
      issue(32'h600, 32'd1, 32'd2, 32'h1, 2'd1, 3'd2, "R6 unsupported bad");
      idle(1);
      // R10: wraparound of target and return address
      issue(32'hFFFF_FFFC, 32'd0, 32'd0, 32'h8, 2'd2, 3'd0, "R10 wrap up");
      issue(32'h0000_0004, 32'd0, 32'd0, 32'hFFFF_FFF8, 2'd1, 3'd0, "R10 wrap down");
      issue(32'h10, 32'hFFFF_FFFF, 32'd0, 32'h5, 2'd3, 3'd0, "R10 indirect wrap");
      // R9: fall-through next address for a valid non-transfer
      issue(32'h7000, 32'd0, 32'd0, 32'h100, 2'd0, 3'd0, "R9 seq");
      idle(3);

      // R11: every request produced exactly one result; idle is quiet
      check(sb.size() == 0, "R11", "pending results", 32'(sb.size()), 32'd0);
      check(!out_valid && !out_taken && !out_link_we && !out_misalign && out_fault_pc == 0,
            "R11", "idle outputs", {out_valid, out_taken, out_link_we, out_misalign}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule